// File: doc/BRIEF.md
# TPM SPI Transaction Opener with Wait-State Polling

This block is the front end of a SPI master that opens register transactions with a TPM-style SPI device. A request carries a read/write flag, a byte count from 1 to 64 and a 24-bit register address. The block builds a 4-byte header and shifts it out with chip select held low. It then honours the device's wait-state flow control by clocking single poll bytes until the device returns a ready bit. The outcome is reported as success or as a flow-control timeout.

A device that has been idle for a long time may be asleep. In that case the block first sends a short chip-select wake pulse followed by a settling gap. The pulse is skipped when a header went out recently. All delays are counted in system clock cycles, derived from a clock-rate parameter and times given in microseconds. The serial clock comes from a parameterised half-period divider. Bus timing is SPI mode 0, MSB first. The data phase that follows a successful opening belongs to the next block. Chip select is released when the result is reported.

Top module: `tpm_spi_fc_master`

## Requirements
- R1: The first header byte is {rd, 1, len-1[5:0]}: bit 7 is 1 for a read and 0 for a write, bit 6 is always 1, and bits 5:0 carry the byte count minus one.
- R2: Header bytes two to four carry the 24-bit address, high byte first. Every byte is sent MSB first in SPI mode 0: sclk idles low, mosi changes only while sclk is low, and miso is sampled on the rising edge.
- R3: A request with len 0 or len above 64 is answered on the next cycle with done and err both high. It causes no chip-select or clock activity.
- R4: The first transaction after reset begins with a wake pulse: cs_n low for WAKE_US microseconds' worth of cycles, then high for GAP_US worth of cycles, then the header.
- R5: The wake pulse is left out when the previous header began fewer than WINDOW_US worth of cycles before the request was accepted. The window restarts at every header start.
- R6: After the header, poll bytes are clocked until the last bit received in a byte (bit 0) is 1. The other received bits have no effect. Success ends with done high and err low.
- R7: If bit 0 of the fourth header byte's received value is already 1, no poll byte is clocked.
- R8: If no ready bit has arrived once TIMEOUT_US worth of cycles have passed since polling began, the block ends at the next byte boundary with done and err high and chip select released.
- R9: A start pulse that arrives while busy is high is ignored.
- R10: busy rises on the cycle after an accepted start and falls when done pulses. done lasts one cycle, err is high only together with done, cs_n is high whenever done is high, and sclk toggles only while cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse |
| rd_i | input | 1 | 1 for a read transaction, 0 for a write |
| len_i | input | 7 | Transfer byte count, legal 1 to 64 |
| addr_i | input | 24 | Device register address |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Rejected request or flow-control timeout, valid with done_o |
| sclk_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |

## Verification
The hardest behaviour to reach is the wake-window decision. It depends on when the previous header began, not on anything in the current request. The stimulus therefore spaces requests deliberately. One test waits longer than the window after the last header to force a pulse. Another issues a chain of requests, each inside the window of its predecessor but spanning more than a window in total, which shows that the window restarts. A responder model in the bench returns 0xFE filler, which has every bit set except the ready bit, so that only bit 0 can end polling. It places the ready byte at a chosen offset, from the fourth header byte onward, or never, to drive the timeout.

// File: rtl/tpm_fc_pkg.sv
package tpm_fc_pkg;

   localparam int unsigned LEN_MAX = 64;
   localparam int unsigned HDR_BYTES = 4;

   typedef enum logic [2:0] {
      FC_IDLE,
      FC_WAKE,
      FC_GAP,
      FC_HDR,
      FC_POLL
   } fc_state_e;

   // header word: type/length byte, then address high..low
   function automatic logic [31:0] make_header(input logic rd,
                                               input logic [6:0] len,
                                               input logic [23:0] addr);
      logic [6:0] lm1;
      lm1 = len - 7'd1;
      return {rd, 1'b1, lm1[5:0], addr};
   endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
   parameter int unsigned HALF_CYC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_i,
   input  logic [7:0] tx_i,
   input  logic       miso_i,
   output logic       sclk_o,
   output logic       mosi_o,
   output logic       done_o,
   output logic [7:0] rx_o
);

   logic       active;
   logic       tick;
   logic [2:0] bit_cnt;
   logic [7:0] tx_sh;
   logic [7:0] rx_sh;

   if (HALF_CYC < 1) begin : g_bad_half
      $error("spi_byte_engine: HALF_CYC must be at least 1");
   end

   if (HALF_CYC == 1) begin : g_nodiv
      assign tick = active;
   end else begin : g_div
      localparam int unsigned HW = $clog2(HALF_CYC);
      logic [HW-1:0] half_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            half_cnt <= '0;
         end else if (!active || half_cnt == HW'(HALF_CYC - 1)) begin
            half_cnt <= '0;
         end else begin
            half_cnt <= half_cnt + 1'b1;
         end
      end
      assign tick = active && (half_cnt == HW'(HALF_CYC - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         sclk_o  <= 1'b0;
         bit_cnt <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (go_i && !active) begin
            active  <= 1'b1;
            sclk_o  <= 1'b0;
            bit_cnt <= '0;
            tx_sh   <= tx_i;
         end else if (tick) begin
            if (!sclk_o) begin
               sclk_o <= 1'b1;
               rx_sh  <= {rx_sh[6:0], miso_i};
            end else begin
               sclk_o <= 1'b0;
               tx_sh  <= {tx_sh[6:0], 1'b0};
               if (bit_cnt == 3'd7) begin
                  active <= 1'b0;
                  done_o <= 1'b1;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
         end
      end
   end

   assign mosi_o = active & tx_sh[7];
   assign rx_o   = rx_sh;

endmodule

// File: rtl/tpm_spi_fc_master.sv
module tpm_spi_fc_master
   import tpm_fc_pkg::*;
#(
   parameter int unsigned CLK_KHZ    = 100000,
   parameter int unsigned SCK_HALF   = 4,
   parameter int unsigned WAKE_US    = 1,
   parameter int unsigned GAP_US     = 100,
   parameter int unsigned TIMEOUT_US = 100000,
   parameter int unsigned WINDOW_US  = 900000,
   parameter logic [7:0]  POLL_FILL  = 8'h00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        rd_i,
   input  logic [6:0]  len_i,
   input  logic [23:0] addr_i,
   output logic        busy_o,
   output logic        done_o,
   output logic        err_o,
   output logic        sclk_o,
   output logic        cs_n_o,
   output logic        mosi_o,
   input  logic        miso_i
);

   localparam longint WAKE_CYC    = longint'(CLK_KHZ) * longint'(WAKE_US) / 1000;
   localparam longint GAP_CYC     = longint'(CLK_KHZ) * longint'(GAP_US) / 1000;
   localparam longint TIMEOUT_CYC = longint'(CLK_KHZ) * longint'(TIMEOUT_US) / 1000;
   localparam longint WINDOW_CYC  = longint'(CLK_KHZ) * longint'(WINDOW_US) / 1000;
   localparam longint DLY_MAX     = (WAKE_CYC > GAP_CYC) ? WAKE_CYC : GAP_CYC;
   localparam int unsigned CW = $clog2(DLY_MAX + 1);
   localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
   localparam int unsigned WW = $clog2(WINDOW_CYC + 1);

   if (WAKE_CYC < 1 || GAP_CYC < 1) begin : g_bad_wake
      $error("tpm_spi_fc_master: wake pulse and gap must be at least one cycle");
   end
   if (TIMEOUT_CYC < 1 || WINDOW_CYC < 1) begin : g_bad_timer
      $error("tpm_spi_fc_master: timeout and window must be at least one cycle");
   end

   fc_state_e   st;
   logic [CW-1:0] dly_cnt;
   logic [TW-1:0] tmo_cnt;
   logic [WW-1:0] win_cnt;
   logic [1:0]  byte_idx;
   logic [31:0] hdr_q;
   logic [31:0] hdr_new;
   logic        len_ok;
   logic        eng_go;
   logic [7:0]  eng_tx;
   logic        eng_done;
   logic [7:0]  eng_rx;

   assign hdr_new = make_header(rd_i, len_i, addr_i);
   assign len_ok  = (len_i != 7'd0) && (len_i <= 7'(LEN_MAX));
   assign busy_o  = (st != FC_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= FC_IDLE;
         dly_cnt  <= '0;
         tmo_cnt  <= '0;
         win_cnt  <= '0;
         byte_idx <= '0;
         hdr_q    <= '0;
         cs_n_o   <= 1'b1;
         done_o   <= 1'b0;
         err_o    <= 1'b0;
         eng_go   <= 1'b0;
         eng_tx   <= '0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         eng_go <= 1'b0;
         if (win_cnt != '0) begin
            win_cnt <= win_cnt - 1'b1;
         end
         unique case (st)
            FC_IDLE: begin
               if (start_i) begin
                  if (!len_ok) begin
                     done_o <= 1'b1;
                     err_o  <= 1'b1;
                  end else if (win_cnt == '0) begin
                     st      <= FC_WAKE;
                     cs_n_o  <= 1'b0;
                     dly_cnt <= CW'(WAKE_CYC - 1);
                     hdr_q   <= hdr_new;
                  end else begin
                     st       <= FC_HDR;
                     cs_n_o   <= 1'b0;
                     win_cnt  <= WW'(WINDOW_CYC);
                     byte_idx <= '0;
                     eng_go   <= 1'b1;
                     eng_tx   <= hdr_new[31:24];
                     hdr_q    <= {hdr_new[23:0], 8'h00};
                  end
               end
            end
            FC_WAKE: begin
               if (dly_cnt == '0) begin
                  st      <= FC_GAP;
                  cs_n_o  <= 1'b1;
                  dly_cnt <= CW'(GAP_CYC - 1);
               end else begin
                  dly_cnt <= dly_cnt - 1'b1;
               end
            end
            FC_GAP: begin
               if (dly_cnt == '0) begin
                  st       <= FC_HDR;
                  cs_n_o   <= 1'b0;
                  win_cnt  <= WW'(WINDOW_CYC);
                  byte_idx <= '0;
                  eng_go   <= 1'b1;
                  eng_tx   <= hdr_q[31:24];
                  hdr_q    <= {hdr_q[23:0], 8'h00};
               end else begin
                  dly_cnt <= dly_cnt - 1'b1;
               end
            end
            FC_HDR: begin
               if (eng_done) begin
                  if (byte_idx == 2'(HDR_BYTES - 1)) begin
                     if (eng_rx[0]) begin
                        st     <= FC_IDLE;
                        cs_n_o <= 1'b1;
                        done_o <= 1'b1;
                     end else begin
                        st      <= FC_POLL;
                        tmo_cnt <= '0;
                        eng_go  <= 1'b1;
                        eng_tx  <= POLL_FILL;
                     end
                  end else begin
                     byte_idx <= byte_idx + 1'b1;
                     eng_go   <= 1'b1;
                     eng_tx   <= hdr_q[31:24];
                     hdr_q    <= {hdr_q[23:0], 8'h00};
                  end
               end
            end
            FC_POLL: begin
               if (tmo_cnt != TW'(TIMEOUT_CYC)) begin
                  tmo_cnt <= tmo_cnt + 1'b1;
               end
               if (eng_done) begin
                  if (eng_rx[0]) begin
                     st     <= FC_IDLE;
                     cs_n_o <= 1'b1;
                     done_o <= 1'b1;
                  end else if (tmo_cnt >= TW'(TIMEOUT_CYC - 1)) begin
                     st     <= FC_IDLE;
                     cs_n_o <= 1'b1;
                     done_o <= 1'b1;
                     err_o  <= 1'b1;
                  end else begin
                     eng_go <= 1'b1;
                     eng_tx <= POLL_FILL;
                  end
               end
            end
            default: st <= FC_IDLE;
         endcase
      end
   end

   spi_byte_engine #(
      .HALF_CYC(SCK_HALF)
   ) eng_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (eng_go),
      .tx_i   (eng_tx),
      .miso_i (miso_i),
      .sclk_o (sclk_o),
      .mosi_o (mosi_o),
      .done_o (eng_done),
      .rx_o   (eng_rx)
   );

endmodule

// File: rtl/tpm_spi_fc_master_chk.sv
module tpm_spi_fc_master_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start_i,
   input logic [6:0]  len_i,
   input logic        busy_o,
   input logic        done_o,
   input logic        err_o,
   input logic        sclk_o,
   input logic        cs_n_o,
   input logic        mosi_o
);

   // R3
   bad_len_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && (len_i == 7'd0 || len_i > 7'd64)) |=> (done_o && err_o && !busy_o));

   // R10
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && len_i != 7'd0 && len_i <= 7'd64) |=> busy_o);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);

   // R10
   done_idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cs_n_o && !busy_o));

   // R10
   sclk_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_o |-> !cs_n_o);

   // R2
   mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

endmodule

bind tpm_spi_fc_master tpm_spi_fc_master_chk chk_i (.*);

// File: tb/tpm_spi_fc_master_tb_top.sv
module tpm_spi_fc_master_tb_top;

   localparam int HALF   = 2;
   localparam int WAKE   = 3;
   localparam int GAP    = 7;
   localparam int TMO    = 400;
   localparam int WINDOW = 1500;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        rd_i = 1'b0;
   logic [6:0]  len_i = '0;
   logic [23:0] addr_i = '0;
   logic        busy_o, done_o, err_o, sclk_o, cs_n_o, mosi_o;
   logic        miso_r = 1'b0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int slave_k = 0;

   // monitor state
   int falls = 0, wakes = 0, rises = 0, rises_tx = 0, dones = 0;
   int low_len = 0, hi_len = 0, wake_len = 0, last_gap = 0, last_fall_cyc = 0, bidx = 0;
   logic [31:0] hdr_bits = '0;
   logic prev_cs = 1'b1, prev_sclk = 1'b0;
   bit   have_hdr = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tpm_spi_fc_master #(
      .CLK_KHZ(1000), .SCK_HALF(HALF), .WAKE_US(WAKE), .GAP_US(GAP),
      .TIMEOUT_US(TMO), .WINDOW_US(WINDOW), .POLL_FILL(8'h00)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .len_i(len_i),
      .addr_i(addr_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_r)
   );

   function automatic logic slave_bit(input int idx, input int k);
      logic [7:0] v;
      v = ((idx / 8) == 3 + k) ? 8'h01 : 8'hFE;
      return v[7 - (idx % 8)];
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs_n_o && prev_cs) begin
            falls++; last_fall_cyc = cyc; last_gap = hi_len;
            low_len = 0; bidx = 0; rises_tx = 0;
         end else if (cs_n_o && !prev_cs) begin
            if (rises_tx == 0) begin wakes++; wake_len = low_len; end
            hi_len = 0;
         end
         if (!cs_n_o) low_len++; else hi_len++;
         if (sclk_o && !prev_sclk) begin
            rises++; rises_tx++;
            if (rises_tx <= 32) hdr_bits = {hdr_bits[30:0], mosi_o};
         end
         if (!sclk_o && prev_sclk) bidx++;
         if (done_o) dones++;
         miso_r = slave_bit(bidx, slave_k);
         prev_cs = cs_n_o; prev_sclk = sclk_o;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // runs one legal request; reports whether a wake pulse was seen
   task automatic run_tx(input logic rd, input logic [6:0] len, input logic [23:0] addr,
                         input int k, input bit exp_err, input int ign_at, output bit woke);
      int f0, w0, r0, d0, t0, n;
      bit exp_wake;
      logic [31:0] exp_hdr;
      logic [6:0] lm1;
      @(negedge clk);
      f0 = falls; w0 = wakes; r0 = rises; d0 = dones;
      slave_k = k;
      exp_wake = !have_hdr || (cyc - last_fall_cyc) >= WINDOW;
      lm1 = len - 7'd1;
      exp_hdr = {rd, 1'b1, lm1[5:0], addr};
      rd_i = rd; len_i = len; addr_i = addr; start_i = 1'b1; t0 = cyc;
      @(negedge clk);
      start_i = 1'b0;
      n = 0;
      while (!done_o && n < 30000) begin
         @(negedge clk); n++;
         if (n == ign_at) begin
            start_i = 1'b1; rd_i = ~rd; len_i = 7'd9; addr_i = ~addr;
         end else begin
            start_i = 1'b0;
         end
      end
      start_i = 1'b0;
      chk(done_o == 1'b1, "R10 watchdog done", done_o, 1);
      have_hdr = 1'b1;
      woke = (wakes - w0) == 1;
      chk(woke == exp_wake, "R5 wake decision", woke, exp_wake);
      if (woke) begin
         chk(wake_len == WAKE, "R4 wake low cycles", wake_len, WAKE);
         chk(last_gap == GAP, "R4 wake gap cycles", last_gap, GAP);
      end
      chk((falls - f0) == (woke ? 2 : 1), "R9 cs falls", falls - f0, woke ? 2 : 1);
      chk(hdr_bits[31:24] == exp_hdr[31:24], "R1 header byte0", hdr_bits[31:24], exp_hdr[31:24]);
      chk(hdr_bits[23:0] == exp_hdr[23:0], "R2 address bytes", hdr_bits[23:0], exp_hdr[23:0]);
      chk(err_o == exp_err, "R8 err flag", err_o, exp_err);
      chk(cs_n_o == 1'b1 && busy_o == 1'b0, "R10 released at done", {cs_n_o, busy_o}, 2'b10);
      if (!exp_err) begin
         chk((rises - r0) == 8 * (4 + k), "R6 R7 clocked bits", rises - r0, 8 * (4 + k));
      end else begin
         chk((cyc - t0) >= TMO, "R8 timeout latency", cyc - t0, TMO);
         chk(((rises - r0) % 8) == 0, "R8 byte boundary", rises - r0, 0);
      end
      @(negedge clk);
      chk((dones - d0) == 1, "R10 single done", dones - d0, 1);
   endtask

   task automatic run_bad(input logic [6:0] len);
      int f0, r0;
      @(negedge clk);
      f0 = falls; r0 = rises;
      len_i = len; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o && err_o, "R3 reject done err", {done_o, err_o}, 2'b11);
      repeat (40) @(negedge clk);
      chk((falls - f0) == 0 && (rises - r0) == 0, "R3 no bus activity", falls - f0, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit w;
      int f0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !done_o && !err_o && cs_n_o && !sclk_o, "R10 reset state",
          {busy_o, done_o, err_o, cs_n_o, sclk_o}, 5'b00010);

      // R3 rejects before any transaction
      run_bad(7'd0);
      run_bad(7'd65);
      run_bad(7'd127);

      // R4 first transaction wakes
      run_tx(1'b1, 7'd4, 24'hD40018, 1, 1'b0, 0, w);
      chk(w == 1'b1, "R4 first wakes", w, 1);

      // R1 R2 R6 R7 sweep over every length, both directions
      for (int i = 0; i < 128; i++) begin
         run_tx(i[0], 7'(i / 2 + 1), 24'h123456 ^ (24'(i) * 24'h010203), i % 3, 1'b0, 0, w);
      end
      run_bad(7'd64 + 7'd1);

      // R9 start while busy
      run_tx(1'b0, 7'd16, 24'hABCDEF, 2, 1'b0, 20, w);
      f0 = falls;
      repeat (100) @(negedge clk);
      chk(falls == f0 && !busy_o, "R9 no extra transaction", falls - f0, 0);

      // R8 device never ready
      run_tx(1'b1, 7'd8, 24'h000F80, 1000, 1'b1, 0, w);

      // R5 window expiry forces wake
      repeat (WINDOW + 100) @(negedge clk);
      run_tx(1'b1, 7'd1, 24'hFFFFFF, 0, 1'b0, 0, w);
      chk(w == 1'b1, "R5 wake after idle window", w, 1);

      // R5 window restarts at every header
      for (int j = 0; j < 3; j++) begin
         repeat (900) @(negedge clk);
         run_tx(1'b0, 7'd2, 24'h00002A + 24'(j), 1, 1'b0, 0, w);
         chk(w == 1'b0, "R5 window restart skip", w, 0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule